// File: doc/BRIEF.md
# R0 Displacement Load/Store Unit

This block executes a family of six 16-bit data-transfer instructions. Each one moves a byte, halfword or word between register R0 and memory at an address formed from a base register plus a short unsigned offset. The upper byte of the instruction gives the direction and the access size. The lower byte gives an offset, which is zero-extended and scaled by the access size. The block drives a memory request for that address, with big-endian byte strobes and lane-replicated store data. It takes the load response, sign-extends it and writes it back to R0.

An instruction is offered on `issue_valid` with the current base and R0 values. While a request or a load is still in flight, `issue_rdy` is low. While a load is outstanding, `stall` is raised whenever the following instruction reads R0 (`next_uses_r0`). The stall drops in the cycle the load data arrives. An upper byte outside the six defined codes sets no request and no stall; it raises `illegal` for that cycle instead.

Top module: `r0_disp_ldst`

## Requirements
- R1: Upper instruction byte 0xC4/0xC5/0xC6 is a load of byte/halfword/word, and 0xC0/0xC1/0xC2 is a store of byte/halfword/word. `mem_size` is 0 for byte, 1 for halfword and 2 for word. `mem_we` is 1 for a store and 0 for a load.
- R2: `mem_addr` equals base plus the zero-extended low instruction byte times 1, 2 or 4 for byte, halfword or word, modulo 2^32. The largest offsets are therefore 255, 510 and 1020.
- R3: Lanes are big-endian, and `mem_be[3]` is lane [31:24], the byte at address offset 0. A byte access has strobe 4'b1000 shifted right by addr[1:0]. A halfword access has strobe 4'b1100 when addr[1] is 0 and 4'b0011 when it is 1. A word access has strobe 4'b1111.
- R4: Store data is R0[7:0] copied into all four lanes for bytes, R0[15:0] copied into both halves for halfwords, and R0 unchanged for words.
- R5: On a load, `r0_we` is high exactly in the cycle `mem_rvalid` returns. `r0_wdata` is the addressed lane or half (chosen as in R3) sign-extended to 32 bits, or the full word.
- R6: `mem_req` rises on the clock edge after an issue is accepted. Address, strobes, size, direction and data then hold until the edge on which `mem_ready` is high, and `mem_req` is low after that edge.
- R7: `stall` equals `next_uses_r0` while a load is outstanding, from the edge after issue until its `mem_rvalid`. It is low in the `mem_rvalid` cycle and at all other times.
- R8: An accepted issue with any other upper byte raises `illegal` in that cycle. It produces no request and no stall.
- R9: `issue_rdy` is low while a request or a load is outstanding. Any instruction offered then is ignored: it produces no `illegal`, and the current request does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Instruction offered this cycle |
| insn | input | 16 | Instruction word |
| base_val | input | 32 | Base register value |
| r0_val | input | 32 | Current R0 value |
| next_uses_r0 | input | 1 | Following instruction reads R0 |
| issue_rdy | output | 1 | Unit can accept an instruction |
| illegal | output | 1 | Offered instruction is not one of the six |
| mem_req | output | 1 | Memory request |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | 32 | Byte address |
| mem_we | output | 1 | 1 = store |
| mem_size | output | 2 | 0 byte, 1 halfword, 2 word |
| mem_be | output | 4 | Byte strobes, bit 3 = lane [31:24] |
| mem_wdata | output | 32 | Store data |
| mem_rvalid | input | 1 | Load data valid |
| mem_rdata | input | 32 | Load data |
| r0_we | output | 1 | R0 write-back enable |
| r0_wdata | output | 32 | R0 write-back value |
| stall | output | 1 | Load-use interlock on R0 |

## Verification
The bench drives the offset at 0xFF for every size and uses bases near the 32-bit wrap. A design that sign-extended the offset or used the wrong scale would produce a smaller or negative address. Every address alignment is exercised, so a little-endian lane order or a halfword lane chosen by the wrong address bit shows up as wrong strobes or wrong load data. Load data is chosen with the lane's top bit both set and clear, to expose a missing or misplaced sign extension. Stall is checked both before and during the response cycle, and illegal or ignored offers are made while the unit is busy and while it is idle, to catch a stall that releases late or a request that leaks through.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  localparam int DATA_W = 32;
  localparam int INSN_W = 16;
  localparam int DISP_W = 8;
  localparam int LANES  = DATA_W / 8;
  localparam int OFS_W  = $clog2(LANES);

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2} acc_size_e;

  typedef struct packed {
    logic      legal;
    logic      is_load;
    acc_size_e size;
  } op_dec_t;

  function automatic logic [DATA_W-1:0] scaled_disp(input logic [DISP_W-1:0] d,
                                                    input acc_size_e sz);
    logic [DATA_W-1:0] z;
    z = {{(DATA_W-DISP_W){1'b0}}, d};
    return z << sz;
  endfunction

  function automatic logic [LANES-1:0] lane_mask(input logic [OFS_W-1:0] ofs,
                                                 input acc_size_e sz);
    case (sz)
      SZ_B:    return 4'b1000 >> ofs;
      SZ_H:    return ofs[1] ? 4'b0011 : 4'b1100;
      default: return 4'b1111;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] replicate(input logic [DATA_W-1:0] v,
                                                  input acc_size_e sz);
    case (sz)
      SZ_B:    return {LANES{v[7:0]}};
      SZ_H:    return {(LANES/2){v[15:0]}};
      default: return v;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] extract_sext(input logic [DATA_W-1:0] d,
                                                     input logic [OFS_W-1:0] ofs,
                                                     input acc_size_e sz);
    logic [7:0]  b;
    logic [15:0] h;
    b = d[(LANES-1-int'(ofs))*8 +: 8];
    h = ofs[1] ? d[15:0] : d[31:16];
    case (sz)
      SZ_B:    return {{(DATA_W-8){b[7]}}, b};
      SZ_H:    return {{(DATA_W-16){h[15]}}, h};
      default: return d;
    endcase
  endfunction
endpackage

// File: rtl/ldst_decode.sv
module ldst_decode
  import ldst_pkg::*;
(
  input  logic [7:0] opc,
  output op_dec_t    dec
);
  always_comb begin
    dec = '{legal: 1'b1, is_load: 1'b0, size: SZ_B};
    case (opc)
      8'hC4: begin dec.is_load = 1'b1; dec.size = SZ_B; end
      8'hC5: begin dec.is_load = 1'b1; dec.size = SZ_H; end
      8'hC6: begin dec.is_load = 1'b1; dec.size = SZ_W; end
      8'hC0: dec.size = SZ_B;
      8'hC1: dec.size = SZ_H;
      8'hC2: dec.size = SZ_W;
      default: dec.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/ldst_agu.sv
module ldst_agu
  import ldst_pkg::*;
#(
  parameter int XW = DATA_W
) (
  input  logic [XW-1:0]     base_val,
  input  logic [DISP_W-1:0] disp,
  input  acc_size_e         size,
  input  logic [XW-1:0]     r0_val,
  output logic [XW-1:0]     ea,
  output logic [LANES-1:0]  be,
  output logic [XW-1:0]     wdata
);
  always_comb begin
    ea    = base_val + scaled_disp(disp, size);
    be    = lane_mask(ea[OFS_W-1:0], size);
    wdata = replicate(r0_val, size);
  end
endmodule

// File: rtl/ldst_ldfmt.sv
module ldst_ldfmt
  import ldst_pkg::*;
#(
  parameter int XW = DATA_W
) (
  input  logic [XW-1:0]    rdata,
  input  logic [OFS_W-1:0] ofs,
  input  acc_size_e        size,
  output logic [XW-1:0]    result
);
  always_comb result = extract_sext(rdata, ofs, size);
endmodule

// File: rtl/r0_disp_ldst.sv
module r0_disp_ldst
  import ldst_pkg::*;
#(
  parameter int XW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_valid,
  input  logic [15:0]   insn,
  input  logic [XW-1:0] base_val,
  input  logic [XW-1:0] r0_val,
  input  logic          next_uses_r0,
  output logic          issue_rdy,
  output logic          illegal,
  output logic          mem_req,
  input  logic          mem_ready,
  output logic [XW-1:0] mem_addr,
  output logic          mem_we,
  output logic [1:0]    mem_size,
  output logic [3:0]    mem_be,
  output logic [XW-1:0] mem_wdata,
  input  logic          mem_rvalid,
  input  logic [XW-1:0] mem_rdata,
  output logic          r0_we,
  output logic [XW-1:0] r0_wdata,
  output logic          stall
);
  op_dec_t             dec;
  logic [XW-1:0]       ea, wd, ld_res;
  logic [LANES-1:0]    be;
  logic                req_q, wait_q, load_q;
  acc_size_e           size_q;
  logic                accept, handshake, data_back, load_outstanding;

  ldst_decode u_dec (.opc(insn[15:8]), .dec(dec));

  ldst_agu #(.XW(XW)) u_agu (
    .base_val(base_val), .disp(insn[DISP_W-1:0]), .size(dec.size),
    .r0_val(r0_val), .ea(ea), .be(be), .wdata(wd)
  );

  ldst_ldfmt #(.XW(XW)) u_fmt (
    .rdata(mem_rdata), .ofs(mem_addr[OFS_W-1:0]), .size(size_q), .result(ld_res)
  );

  assign issue_rdy        = !(req_q || wait_q);
  assign accept           = issue_valid && issue_rdy && dec.legal;
  assign illegal          = issue_valid && issue_rdy && !dec.legal;
  assign handshake        = req_q && mem_ready;
  assign data_back        = wait_q && mem_rvalid;
  assign load_outstanding = (req_q && load_q) || wait_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q     <= 1'b0;
      wait_q    <= 1'b0;
      load_q    <= 1'b0;
      size_q    <= SZ_B;
      mem_addr  <= '0;
      mem_be    <= '0;
      mem_wdata <= '0;
    end else begin
      if (accept) begin
        req_q     <= 1'b1;
        load_q    <= dec.is_load;
        size_q    <= dec.size;
        mem_addr  <= ea;
        mem_be    <= be;
        mem_wdata <= wd;
      end else if (handshake) begin
        req_q  <= 1'b0;
        wait_q <= load_q;
      end
      if (data_back) wait_q <= 1'b0;
    end
  end

  assign mem_req  = req_q;
  assign mem_we   = !load_q;
  assign mem_size = size_q;
  assign r0_we    = data_back;
  assign r0_wdata = ld_res;
  assign stall    = next_uses_r0 && load_outstanding && !data_back;
endmodule

// File: rtl/ldst_checker.sv
module ldst_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        issue_valid,
  input logic        issue_rdy,
  input logic        illegal,
  input logic        mem_req,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [1:0]  mem_size,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic        mem_rvalid,
  input logic        r0_we,
  input logic        stall,
  input logic        next_uses_r0,
  input logic        load_outstanding
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata)); // R6
  AST_REQ_AFTER_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(issue_valid && issue_rdy)); // R6
  AST_BE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> $countones(mem_be) == (mem_size == 2'd0 ? 1 : (mem_size == 2'd1 ? 2 : 4))); // R3
  AST_WB_ON_RVALID: assert property (@(posedge clk) disable iff (!rst_n)
    r0_we |-> mem_rvalid && !mem_req); // R5
  AST_STALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> next_uses_r0 && load_outstanding && !mem_rvalid); // R7
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !mem_req && !stall); // R8
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !issue_rdy && !illegal); // R9
endmodule

bind r0_disp_ldst ldst_checker u_chk (
  .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_rdy(issue_rdy),
  .illegal(illegal), .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_size(mem_size), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid),
  .r0_we(r0_we), .stall(stall), .next_uses_r0(next_uses_r0),
  .load_outstanding(load_outstanding)
);

// File: tb/sim_r0_disp_ldst.sv
module sim_r0_disp_ldst;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_valid = 1'b0;
  logic [15:0] insn = '0;
  logic [31:0] base_val = '0, r0_val = '0, mem_rdata = '0;
  logic        next_uses_r0 = 1'b0, mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic        issue_rdy, illegal, mem_req, mem_we, r0_we, stall;
  logic [31:0] mem_addr, mem_wdata, r0_wdata;
  logic [1:0]  mem_size;
  logic [3:0]  mem_be;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  r0_disp_ldst u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected-value functions, stated from the requirements
  function automatic int op_kind(input logic [7:0] o); // 0..2 load, 3..5 store, -1 other
    case (o)
      8'hC4: return 0; 8'hC5: return 1; 8'hC6: return 2;
      8'hC0: return 3; 8'hC1: return 4; 8'hC2: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] b, input logic [7:0] d, input int sz);
    int mul;
    mul = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    return b + 32'(d) * 32'(mul);
  endfunction

  function automatic logic [3:0] exp_be(input logic [1:0] a, input int sz);
    if (sz == 2) return 4'hF;
    if (sz == 1) return (a >= 2) ? 4'b0011 : 4'b1100;
    case (a) 2'd0: return 4'b1000; 2'd1: return 4'b0100; 2'd2: return 4'b0010; default: return 4'b0001; endcase
  endfunction

  function automatic logic [31:0] exp_wd(input logic [31:0] r, input int sz);
    if (sz == 0) return {r[7:0], r[7:0], r[7:0], r[7:0]};
    if (sz == 1) return {r[15:0], r[15:0]};
    return r;
  endfunction

  function automatic logic [31:0] exp_ld(input logic [31:0] d, input logic [1:0] a, input int sz);
    logic [7:0] by [4];
    logic [15:0] hw;
    by[0] = d[31:24]; by[1] = d[23:16]; by[2] = d[15:8]; by[3] = d[7:0];
    if (sz == 0) return by[a][7] ? {24'hFFFFFF, by[a]} : {24'h0, by[a]};
    if (sz == 1) begin
      hw = (a >= 2) ? {by[2], by[3]} : {by[0], by[1]};
      return hw[15] ? {16'hFFFF, hw} : {16'h0, hw};
    end
    return d;
  endfunction

  task automatic run_op(input logic [15:0] ins, input logic [31:0] b, input logic [31:0] r,
                        input logic [31:0] rd, input int lat);
    int k, sz;
    logic [31:0] ea;
    k = op_kind(ins[15:8]);
    sz = (k < 0) ? 0 : k % 3;
    ea = exp_addr(b, ins[7:0], sz);
    @(negedge clk);
    issue_valid = 1'b1; insn = ins; base_val = b; r0_val = r;
    #1;
    chk(issue_rdy === 1'b1, "R9 idle ready", {31'b0, issue_rdy}, 32'd1);
    chk(illegal === (k < 0), "R8 illegal flag", {31'b0, illegal}, {31'b0, k < 0});
    @(negedge clk);
    issue_valid = 1'b0; next_uses_r0 = 1'b1;
    #1;
    if (k < 0) begin
      chk(mem_req === 1'b0, "R8 no request", {31'b0, mem_req}, 32'd0);
      chk(stall === 1'b0, "R8 no stall", {31'b0, stall}, 32'd0);
      next_uses_r0 = 1'b0;
      return;
    end
    chk(mem_req === 1'b1, "R6 request raised", {31'b0, mem_req}, 32'd1);
    chk(mem_we === (k >= 3), "R1 direction", {31'b0, mem_we}, {31'b0, k >= 3});
    chk(mem_size === 2'(sz), "R1 size", {30'b0, mem_size}, 32'(sz));
    chk(mem_addr === ea, "R2 address", mem_addr, ea);
    chk(mem_be === exp_be(ea[1:0], sz), "R3 strobes", {28'b0, mem_be}, {28'b0, exp_be(ea[1:0], sz)});
    if (k >= 3) chk(mem_wdata === exp_wd(r, sz), "R4 store data", mem_wdata, exp_wd(r, sz));
    chk(stall === (k < 3), "R7 stall during request", {31'b0, stall}, {31'b0, k < 3});
    for (int i = 0; i < lat; i++) begin
      issue_valid = 1'b1; insn = 16'h00FF; base_val = ~b;
      #1;
      chk(issue_rdy === 1'b0 && illegal === 1'b0, "R9 busy offer", {30'b0, issue_rdy, illegal}, 32'd0);
      @(negedge clk);
      issue_valid = 1'b0;
      #1;
      chk(mem_req === 1'b1 && mem_addr === ea, "R6 hold", mem_addr, ea);
    end
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    #1;
    chk(mem_req === 1'b0, "R6 drop after ready", {31'b0, mem_req}, 32'd0);
    if (k >= 3) begin
      chk(stall === 1'b0 && issue_rdy === 1'b1, "R7 no stall on store", {30'b0, stall, issue_rdy}, 32'd1);
      next_uses_r0 = 1'b0;
      return;
    end
    chk(stall === 1'b1, "R7 stall while waiting", {31'b0, stall}, 32'd1);
    next_uses_r0 = 1'b0;
    #1;
    chk(stall === 1'b0, "R7 follows next_uses_r0", {31'b0, stall}, 32'd0);
    next_uses_r0 = 1'b1;
    @(negedge clk);
    mem_rvalid = 1'b1; mem_rdata = rd;
    #1;
    chk(r0_we === 1'b1, "R5 write enable", {31'b0, r0_we}, 32'd1);
    chk(r0_wdata === exp_ld(rd, ea[1:0], sz), "R5 load value", r0_wdata, exp_ld(rd, ea[1:0], sz));
    chk(stall === 1'b0, "R7 release on rvalid", {31'b0, stall}, 32'd0);
    @(negedge clk);
    mem_rvalid = 1'b0;
    #1;
    chk(r0_we === 1'b0 && stall === 1'b0 && issue_rdy === 1'b1, "R7 idle after load",
        {29'b0, r0_we, stall, issue_rdy}, 32'd1);
    next_uses_r0 = 1'b0;
  endtask

  initial begin : wd
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] ops [6];
    int s;
    ops = '{8'hC4, 8'hC5, 8'hC6, 8'hC0, 8'hC1, 8'hC2};
    s = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    #1;
    chk(mem_req === 1'b0 && stall === 1'b0 && r0_we === 1'b0 && issue_rdy === 1'b1,
        "R6 reset state", {28'b0, mem_req, stall, r0_we, issue_rdy}, 32'd1);
    rst_n = 1'b1;
    // directed: maximum offset for each size, near the wrap point
    for (int i = 0; i < 6; i++) run_op({ops[i], 8'hFF}, 32'hFFFF_FF00, 32'h8765_43A9, 32'h80FF_7F01, 1);
    // directed: every alignment, both sign polarities
    for (int a = 0; a < 4; a++) begin
      run_op({8'hC4, 8'h00}, 32'h1000 + 32'(a), 32'h0, 32'h8001_7F80, 0);
      run_op({8'hC4, 8'h00}, 32'h1000 + 32'(a), 32'h0, 32'h7F80_807F, 0);
      run_op({8'hC5, 8'h00}, 32'h2000 + 32'(a), 32'h0, 32'h8000_7FFF, 0);
      run_op({8'hC0, 8'h00}, 32'h3000 + 32'(a), 32'hAABB_CCDD, 32'h0, 0);
      run_op({8'hC1, 8'h00}, 32'h3000 + 32'(a), 32'hAABB_CCDD, 32'h0, 2);
    end
    run_op(16'hC3_10, 32'h0, 32'h0, 32'h0, 0); // R8 neighbour of a legal code
    run_op(16'h44_10, 32'h0, 32'h0, 32'h0, 0); // R8
    // random
    for (int n = 0; n < 400; n++) begin
      logic [15:0] ins;
      ins = {($urandom % 8 == 0) ? 8'($urandom) : ops[$urandom % 6], 8'($urandom)};
      run_op(ins, $urandom, $urandom, $urandom, $urandom % 3);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule